// File: doc/BRIEF.md
# Core Regulator Power-Up Sequencer

This block is the control engine that brings a multiphase core regulator from off to regulated output in a fixed order. It waits until the enable input and the undervoltage-lockout-clear input are both true. It then steps through a set of timed phases: a start delay, a short phase-detection window with the PWM outputs blanked, a ramp to a fixed boot level, a boot hold, a ramp to the voltage code the processor requests, a power-good masking interval and a power-good blanking delay. After the last phase it asserts power-good.

The PWM engine, the DAC, the ramp generator and the serial register bank are outside the block. The delay settings arrive as plain register inputs, counted in microseconds. An internal prescaler turns the system clock into a 1 µs tick. The block tells the ramp generator when to start and which code to aim for, and it waits for that generator's done flag. A one-hot phase output lets the phase order and the phase lengths be observed directly.

Top module: `vr_powerup_seq`

## Requirements
- R1: While `enable` and `uvloOk` are not both high, the sequencer stays idle. In idle, `stateOneHot` = 9'b000000001, `pwmBlank` = 1 and `powerGood` = 0.
- R2: The start-delay phase (`stateOneHot` bit 1) lasts `startDly`×`CLK_PER_US` clock cycles, and one cycle when `startDly` is 0.
- R3: The phase-detection window (bit 2) lasts exactly `DETECT_CYC` clock cycles (default 8). `pwmBlank` is 1 in phases 0 to 2 and 0 in phases 3 to 8.
- R4: On entry to the boot ramp (bit 3), `rampStart` pulses for one cycle while `rampTarget` = `BOOT_CODE`. The phase ends once `rampDone` is seen after that pulse.
- R5: The boot hold (bit 4) uses the same `startDly` setting and lasts the same number of cycles as the start delay.
- R6: The value of `vidCode` in the last cycle of the boot hold is latched. On entry to the target ramp (bit 5), `rampStart` and `vidStrobe` each pulse once with `rampTarget` equal to the latched code. Later changes of `vidCode` do not alter `rampTarget`.
- R7: After the target ramp's `rampDone`, the masking phase (bit 6) lasts `maskDly`×`CLK_PER_US` cycles and the blanking phase (bit 7) lasts `blankDly`×`CLK_PER_US` cycles, or one cycle each for a zero setting. `powerGood` is 1 exactly while in the final phase (bit 8).
- R8: If `enable` or `uvloOk` is low at a clock edge, the sequencer is idle after that edge, whatever phase it was in, with `powerGood` = 0 and `pwmBlank` = 1.
- R9: A zero delay setting shortens its phase to one cycle and never stalls the sequence.
- R10: `stateOneHot` always has exactly one bit set. Its index only ever steps up by one or returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Regulator enable request |
| uvloOk | input | 1 | Supply above undervoltage lockout |
| vidCode | input | VID_W | Processor-requested voltage code |
| startDly | input | DLY_W | Start delay and boot hold, in µs |
| maskDly | input | DLY_W | Power-good masking interval, in µs |
| blankDly | input | DLY_W | Power-good blanking delay, in µs |
| rampDone | input | 1 | Ramp generator has reached its target |
| pwmBlank | output | 1 | Hold PWM outputs off |
| rampStart | output | 1 | One-cycle pulse starting a ramp |
| rampTarget | output | VID_W | Code the ramp should reach |
| vidStrobe | output | 1 | One-cycle pulse when the voltage code is taken |
| powerGood | output | 1 | Output is up and settled |
| stateOneHot | output | 9 | Current phase, one-hot, bit index = phase order |

## Verification
The full sequence is run with non-zero delays of different sizes for the start, masking and blanking settings. Because each measured phase length maps back to one setting, a swapped delay select or a wrong tick scale shows up. A second run uses all-zero delays, which separates the one-cycle minimum from an underflowed counter that would stall. The voltage code is changed right after the hold ends, so a target that follows the live input can be told apart from a latched one. Gating is tried with each qualifier low on its own. Aborts are tried in the middle of the boot hold and from the final power-good phase.

// File: rtl/vr_seq_pkg.sv
package vr_seq_pkg;

  // Phase encoding: the numeric order is the sequence order.
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_WAIT    = 4'd1,
    ST_DETECT  = 4'd2,
    ST_SSBOOT  = 4'd3,
    ST_HOLD    = 4'd4,
    ST_RAMPVID = 4'd5,
    ST_MASK    = 4'd6,
    ST_BLANK   = 4'd7,
    ST_GOOD    = 4'd8
  } seqState_e;

  localparam int NUM_STATES = 9;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_BLANK = 2'd2
  } dlySel_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic    clrTimer;
    logic    latchVid;
    logic    selVid;
    dlySel_e dlySel;
  } seqStrobe_t;

endpackage

// File: rtl/vr_seq_dp.sv
module vr_seq_dp
  import vr_seq_pkg::*;
#(
  parameter int              CLK_PER_US = 100,
  parameter int              DLY_W      = 12,
  parameter int              VID_W      = 8,
  parameter int              DETECT_CYC = 8,
  parameter logic [VID_W-1:0] BOOT_CODE = 8'h3C
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [DLY_W-1:0] startDly,
  input  logic [DLY_W-1:0] maskDly,
  input  logic [DLY_W-1:0] blankDly,
  input  logic [VID_W-1:0] vidCode,
  output logic             timerDone,
  output logic             detectDone,
  output logic [VID_W-1:0] rampTarget
);

  localparam int PSC_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int DET_W = $clog2(DETECT_CYC + 1);
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(CLK_PER_US - 1);
  localparam logic [DET_W-1:0] DET_LAST = DET_W'(DETECT_CYC - 1);

  logic [PSC_W-1:0] psc;
  logic [DLY_W-1:0] usCnt;
  logic [DET_W-1:0] detCnt;
  logic [VID_W-1:0] vidHeld;
  logic [DLY_W-1:0] dlyCur;
  logic             pscWrap;

  assign pscWrap = (psc == PSC_LAST);

  always_comb begin
    unique case (strobe.dlySel)
      SEL_MASK:  dlyCur = maskDly;
      SEL_BLANK: dlyCur = blankDly;
      default:   dlyCur = startDly;
    endcase
  end

  // Prescaler, microsecond counter and detection-window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psc    <= '0;
      usCnt  <= '0;
      detCnt <= '0;
    end else if (strobe.clrTimer) begin
      psc    <= '0;
      usCnt  <= '0;
      detCnt <= '0;
    end else begin
      if (pscWrap) begin
        psc   <= '0;
        usCnt <= usCnt + 1'b1;
      end else begin
        psc <= psc + 1'b1;
      end
      if (detCnt != DET_LAST) detCnt <= detCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                vidHeld <= '0;
    else if (strobe.latchVid) vidHeld <= vidCode;
  end

  // A zero setting finishes in the first cycle of its phase
  assign timerDone  = (dlyCur == '0) ||
                      (pscWrap && (usCnt == dlyCur - DLY_W'(1)));
  assign detectDone = (detCnt == DET_LAST);
  assign rampTarget = strobe.selVid ? vidHeld : BOOT_CODE;

  // The held code may change only at a latch strobe
  p_vid_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.latchVid) |-> $stable(vidHeld));

endmodule

// File: rtl/vr_seq_ctrl.sv
module vr_seq_ctrl
  import vr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       uvloOk,
  input  logic       rampDone,
  input  logic       timerDone,
  input  logic       detectDone,
  output seqStrobe_t strobe,
  output seqState_e  state,
  output logic       rampStart,
  output logic       vidStrobe,
  output logic       pwmBlank,
  output logic       powerGood
);

  seqState_e nxt;
  logic      enOk;
  logic      latchNow;
  logic      startNow;

  assign enOk = enable && uvloOk;

  always_comb begin
    nxt = state;
    if (!enOk) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    nxt = ST_WAIT;
        ST_WAIT:    if (timerDone)              nxt = ST_DETECT;
        ST_DETECT:  if (detectDone)             nxt = ST_SSBOOT;
        ST_SSBOOT:  if (rampDone && !rampStart) nxt = ST_HOLD;
        ST_HOLD:    if (timerDone)              nxt = ST_RAMPVID;
        ST_RAMPVID: if (rampDone && !rampStart) nxt = ST_MASK;
        ST_MASK:    if (timerDone)              nxt = ST_BLANK;
        ST_BLANK:   if (timerDone)              nxt = ST_GOOD;
        default:    nxt = state;
      endcase
    end
  end

  assign latchNow = (state == ST_HOLD) && (nxt == ST_RAMPVID);
  assign startNow = ((nxt == ST_SSBOOT) && (state != ST_SSBOOT)) || latchNow;

  always_comb begin
    strobe.clrTimer = (nxt != state);
    strobe.latchVid = latchNow;
    strobe.selVid   = (state >= ST_RAMPVID);
    unique case (state)
      ST_MASK:  strobe.dlySel = SEL_MASK;
      ST_BLANK: strobe.dlySel = SEL_BLANK;
      default:  strobe.dlySel = SEL_START;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rampStart <= 1'b0;
      vidStrobe <= 1'b0;
    end else begin
      state     <= nxt;
      rampStart <= startNow;
      vidStrobe <= latchNow;
    end
  end

  assign pwmBlank  = (state == ST_IDLE) || (state == ST_WAIT) || (state == ST_DETECT);
  assign powerGood = (state == ST_GOOD);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && uvloOk) |=> (state == ST_IDLE) && !rampStart && !vidStrobe);

  p_order_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != $past(state)) && (state != ST_IDLE) |->
      (4'(state) == 4'($past(state)) + 4'd1));

  p_vid_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    vidStrobe |-> (state == ST_RAMPVID) && ($past(state) == ST_HOLD) && rampStart);

  p_ramp_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    rampStart |-> ((state == ST_SSBOOT) || (state == ST_RAMPVID)) && (state != $past(state)));

  p_good_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |-> ($past(state) == ST_BLANK) && $past(timerDone));

  p_detect_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SSBOOT) && ($past(state) == ST_DETECT) |-> $past(detectDone));

endmodule

// File: rtl/vr_powerup_seq.sv
module vr_powerup_seq
  import vr_seq_pkg::*;
#(
  parameter int               CLK_PER_US = 100,
  parameter int               DLY_W      = 12,
  parameter int               VID_W      = 8,
  parameter int               DETECT_CYC = 8,
  parameter logic [VID_W-1:0] BOOT_CODE  = 8'h3C
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  uvloOk,
  input  logic [VID_W-1:0]      vidCode,
  input  logic [DLY_W-1:0]      startDly,
  input  logic [DLY_W-1:0]      maskDly,
  input  logic [DLY_W-1:0]      blankDly,
  input  logic                  rampDone,
  output logic                  pwmBlank,
  output logic                  rampStart,
  output logic [VID_W-1:0]      rampTarget,
  output logic                  vidStrobe,
  output logic                  powerGood,
  output logic [NUM_STATES-1:0] stateOneHot
);

  seqStrobe_t strobe;
  seqState_e  state;
  logic       timerDone;
  logic       detectDone;

  vr_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .uvloOk     (uvloOk),
    .rampDone   (rampDone),
    .timerDone  (timerDone),
    .detectDone (detectDone),
    .strobe     (strobe),
    .state      (state),
    .rampStart  (rampStart),
    .vidStrobe  (vidStrobe),
    .pwmBlank   (pwmBlank),
    .powerGood  (powerGood)
  );

  vr_seq_dp #(
    .CLK_PER_US (CLK_PER_US),
    .DLY_W      (DLY_W),
    .VID_W      (VID_W),
    .DETECT_CYC (DETECT_CYC),
    .BOOT_CODE  (BOOT_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startDly   (startDly),
    .maskDly    (maskDly),
    .blankDly   (blankDly),
    .vidCode    (vidCode),
    .timerDone  (timerDone),
    .detectDone (detectDone),
    .rampTarget (rampTarget)
  );

  assign stateOneHot = NUM_STATES'(1) << state;

endmodule

// File: tb/vr_powerup_seq_bench.sv
module vr_powerup_seq_bench;

  localparam int         CPU   = 4;
  localparam logic [7:0] BOOTC = 8'h3C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       uvloOk = 1'b0;
  logic [7:0] vidCode = 8'h00;
  logic [7:0] startDly = 8'd0;
  logic [7:0] maskDly = 8'd0;
  logic [7:0] blankDly = 8'd0;
  logic       rampDone;
  logic       pwmBlank, rampStart, vidStrobe, powerGood;
  logic [7:0] rampTarget;
  logic [8:0] stOneHot;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  vr_powerup_seq #(
    .CLK_PER_US (CPU),
    .DLY_W      (8),
    .VID_W      (8),
    .DETECT_CYC (8),
    .BOOT_CODE  (BOOTC)
  ) u_vr_powerup_seq (
    .clk (clk), .rstN (rstN), .enable (enable), .uvloOk (uvloOk),
    .vidCode (vidCode), .startDly (startDly), .maskDly (maskDly),
    .blankDly (blankDly), .rampDone (rampDone), .pwmBlank (pwmBlank),
    .rampStart (rampStart), .rampTarget (rampTarget), .vidStrobe (vidStrobe),
    .powerGood (powerGood), .stateOneHot (stOneHot)
  );

  // Ramp generator model: done pulse five cycles after each start
  initial begin
    rampDone = 1'b0;
    forever begin
      @(negedge clk);
      if (rampStart) begin
        repeat (5) @(negedge clk);
        rampDone = 1'b1;
        @(negedge clk);
        rampDone = 1'b0;
      end
    end
  end

  // Phase monitor, sampled at the falling edge
  int dur[9];
  int curCnt = 0;
  int prevIdx = 0;
  int orderBad = 0, blankBad = 0, pgBad = 0, ohBad = 0, vidStrobeCnt = 0;
  logic [7:0] bootTgt = 8'h00, vidTgt = 8'h00;

  function automatic int idxOf(logic [8:0] v);
    for (int i = 0; i < 9; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      int cur;
      cur = idxOf(stOneHot);
      if ($countones(stOneHot) != 1) ohBad++;
      if (cur == prevIdx) curCnt++;
      else begin
        if (prevIdx >= 0) dur[prevIdx] = curCnt;
        curCnt = 1;
        if (!(cur == prevIdx + 1 || cur == 0)) orderBad++;
      end
      prevIdx = cur;
      if ((cur <= 2) != pwmBlank) blankBad++;
      if ((cur == 8) != powerGood) pgBad++;
      if (rampStart && cur == 3) bootTgt = rampTarget;
      if (rampStart && cur == 5) vidTgt = rampTarget;
      if (vidStrobe) vidStrobeCnt++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitBit(int b, int lim);
    int n = 0;
    while (!stOneHot[b] && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(stOneHot[b], "R10", "phase not reached", idxOf(stOneHot), b);
  endtask

  function automatic int expLen(int d);
    return (d == 0) ? 1 : d * CPU;
  endfunction

  task automatic testReset();
    @(negedge clk);
    chk(stOneHot == 9'b1, "R1", "reset phase", stOneHot, 1);
    chk(pwmBlank == 1'b1, "R1", "reset pwmBlank", pwmBlank, 1);
    chk(powerGood == 1'b0, "R1", "reset powerGood", powerGood, 0);
    chk(rampStart == 1'b0, "R1", "reset rampStart", rampStart, 0);
  endtask

  task automatic testGating();
    enable = 1'b1; uvloOk = 1'b0;
    repeat (40) @(negedge clk);
    chk(stOneHot == 9'b1, "R1", "enable only, phase", stOneHot, 1);
    enable = 1'b0; uvloOk = 1'b1;
    repeat (40) @(negedge clk);
    chk(stOneHot == 9'b1, "R1", "uvloOk only, phase", stOneHot, 1);
    chk(pwmBlank && !powerGood, "R1", "gated outputs", {pwmBlank, powerGood}, 2);
    uvloOk = 1'b0;
  endtask

  task automatic runSeq(int sd, int mk, int bl, logic [7:0] vid, string tag);
    int ob0 = orderBad, bb0 = blankBad, pb0 = pgBad, oh0 = ohBad, vs0 = vidStrobeCnt;
    @(negedge clk);
    startDly = 8'(sd); maskDly = 8'(mk); blankDly = 8'(bl); vidCode = vid;
    enable = 1'b1; uvloOk = 1'b1;
    waitBit(5, 4000);
    vidCode = ~vid;
    waitBit(8, 4000);
    repeat (3) @(negedge clk);
    chk(dur[1] == expLen(sd), "R2", {tag, " start delay length"}, dur[1], expLen(sd));
    chk(dur[2] == 8, "R3", {tag, " detect window length"}, dur[2], 8);
    chk(blankBad == bb0, "R3", {tag, " pwmBlank per phase"}, blankBad - bb0, 0);
    chk(bootTgt == BOOTC, "R4", {tag, " boot ramp target"}, bootTgt, BOOTC);
    chk(dur[4] == expLen(sd), "R5", {tag, " boot hold length"}, dur[4], expLen(sd));
    chk(vidTgt == vid, "R6", {tag, " target at ramp start"}, vidTgt, vid);
    chk(rampTarget == vid, "R6", {tag, " target after input change"}, rampTarget, vid);
    chk(vidStrobeCnt - vs0 == 1, "R6", {tag, " vid strobe count"}, vidStrobeCnt - vs0, 1);
    chk(dur[6] == expLen(mk), "R7", {tag, " mask length"}, dur[6], expLen(mk));
    chk(dur[7] == expLen(bl), "R7", {tag, " blank length"}, dur[7], expLen(bl));
    chk(powerGood && pgBad == pb0, "R7", {tag, " powerGood only in final"}, pgBad - pb0, 0);
    chk(orderBad == ob0 && ohBad == oh0, "R10", {tag, " phase order"}, orderBad - ob0 + ohBad - oh0, 0);
    // abort from the power-good phase
    enable = 1'b0;
    @(negedge clk);
    chk(stOneHot == 9'b1 && pwmBlank && !powerGood, "R8", {tag, " abort from good"}, stOneHot, 1);
  endtask

  task automatic testZero();
    runSeq(0, 0, 0, 8'h21, "zero");
    chk(dur[1] == 1 && dur[6] == 1 && dur[7] == 1, "R9", "zero delays one cycle",
        dur[1] + dur[6] + dur[7], 3);
  endtask

  task automatic testAbortHold();
    @(negedge clk);
    startDly = 8'd6; maskDly = 8'd1; blankDly = 8'd1; vidCode = 8'h44;
    enable = 1'b1; uvloOk = 1'b1;
    waitBit(4, 4000);
    repeat (3) @(negedge clk);
    uvloOk = 1'b0;
    @(negedge clk);
    chk(stOneHot == 9'b1, "R8", "abort in hold, phase", stOneHot, 1);
    chk(pwmBlank && !powerGood && !rampStart, "R8", "abort in hold, outputs",
        {pwmBlank, powerGood, rampStart}, 4);
    repeat (20) @(negedge clk);
    chk(stOneHot == 9'b1, "R1", "stays idle after abort", stOneHot, 1);
    enable = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) dur[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testGating();
    runSeq(3, 2, 5, 8'h5A, "main");
    runSeq(7, 4, 1, 8'hA3, "alt");
    testZero();
    testAbortHold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule